// File: doc/BRIEF.md
# Target Request Completion Classifier

This block sits on the receive side of a device endpoint, behind the request decoder, and decides how each incoming request is answered. For every request strobe it looks at the request class (configuration or memory/IO, posted or non-posted), the decoder's two verdicts (is the request supported, does it violate the device programming model), whether local configuration loading has finished, and the device power state. It folds these into one priority-ordered verdict: retry, unsupported, abort or success.

The verdict comes out registered, one cycle after the strobe. It carries a completion status for non-posted requests, a discard strobe for requests that must not be executed, and a system-error pulse for posted error requests. Two enables gate that pulse. A sticky unsupported-request-detected flag records any unsupported request until software clears it with a write-one-to-clear strobe. Packet formatting and completion data are handled elsewhere.

Top module: `tgt_cpl_classifier`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released with no request, cpl_valid, cpl_status, discard, serr_pulse and ur_detected are all 0.
- R2: Outputs reflect a request sampled with req_valid=1 at clock edge N during the cycle after edge N only. After an edge that sampled req_valid=0, cpl_valid, discard and serr_pulse are 0 and cpl_status is 3'b000.
- R3: A request is non-posted when req_cfg=1 or req_posted=0. Configuration requests are always non-posted. cpl_valid is 1 exactly for non-posted requests, and cpl_status is 3'b000 for posted ones.
- R4: A configuration request while init_done=0 gets cpl_status 3'b010 (retry), regardless of the decoder verdicts. It is not discarded, raises no system error and does not set ur_detected.
- R5: A request that is not a retry and has req_supported=0 is unsupported. It is discarded, and if non-posted it gets cpl_status 3'b001.
- R6: With pwr_d3=1, every non-configuration request is unsupported (R5 applies) whatever req_supported says. Configuration requests are classified as in D0.
- R7: A request that is neither retry nor unsupported but has req_model_err=1 is discarded, and if non-posted it gets cpl_status 3'b100 (completer abort). Unsupported takes priority over abort.
- R8: A request with none of the conditions above is not discarded and, if non-posted, gets cpl_status 3'b000.
- R9: serr_pulse is 1 for a posted request that is unsupported or aborted, and only when serr_en=1 and urre_en=1. It is never 1 for a non-posted request.
- R10: ur_detected becomes 1 in the cycle after any unsupported request (posted or not) and stays 1. Abort and retry outcomes do not set it.
- R11: ur_clear=1 sampled at an edge clears ur_detected from the next cycle on, unless an unsupported request is sampled at the same edge, in which case ur_detected stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_cfg | input | 1 | 1 = configuration request, 0 = memory/IO |
| req_posted | input | 1 | 1 = posted request (ignored for configuration) |
| req_supported | input | 1 | Decoder verdict: request type is supported |
| req_model_err | input | 1 | Decoder verdict: request violates the programming model |
| init_done | input | 1 | Local configuration load has finished |
| pwr_d3 | input | 1 | 1 = device in D3, 0 = D0 |
| serr_en | input | 1 | System-error enable |
| urre_en | input | 1 | Unsupported-request reporting enable |
| ur_clear | input | 1 | Write-one-to-clear strobe for ur_detected |
| cpl_valid | output | 1 | A completion is due for the registered request |
| cpl_status | output | 3 | Completion status: 000 success, 001 unsupported, 010 retry, 100 abort |
| discard | output | 1 | Registered request must be dropped |
| serr_pulse | output | 1 | One-cycle system-error signal |
| ur_detected | output | 1 | Sticky unsupported-request-detected flag |

## Verification
The bench sweeps all 256 combinations of request class, posting, decoder verdicts, init state, power state and both enables. Each request is followed by an idle cycle, so priority clashes such as retry against unsupported, unsupported against abort, and D3 against configuration are all exercised and told apart by the status code. Before each request the sticky flag is cleared on its own, which separates set-by-unsupported from set-by-abort or set-by-retry. A final case drives the clear strobe in the same cycle as an unsupported request to show that setting wins.

// File: rtl/tgt_cpl_pkg.sv
package tgt_cpl_pkg;

  localparam int STS_W = 3;

  typedef enum logic [STS_W-1:0] {
    CPL_SC  = 3'b000,
    CPL_UR  = 3'b001,
    CPL_CRS = 3'b010,
    CPL_CA  = 3'b100
  } cpl_sts_e;

  typedef struct packed {
    logic np;   // completion owed
    logic crs;  // retry while initialising
    logic ur;   // unsupported
    logic ca;   // completer abort
  } verdict_t;

endpackage

// File: rtl/tgt_req_decide.sv
module tgt_req_decide
  import tgt_cpl_pkg::*;
(
  input  logic     req_cfg,
  input  logic     req_posted,
  input  logic     req_supported,
  input  logic     req_model_err,
  input  logic     init_done,
  input  logic     pwr_d3,
  output verdict_t verdict
);

  logic is_np;
  logic is_crs;
  logic is_ur;
  logic is_ca;

  always_comb begin
    is_np  = req_cfg | ~req_posted;
    is_crs = req_cfg & ~init_done;
    is_ur  = ~is_crs & (~req_supported | (pwr_d3 & ~req_cfg));
    is_ca  = ~is_crs & ~is_ur & req_model_err;
    verdict = '{np: is_np, crs: is_crs, ur: is_ur, ca: is_ca};
  end

endmodule

// File: rtl/tgt_resp_reg.sv
module tgt_resp_reg
  import tgt_cpl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  verdict_t         verdict,
  input  logic             serr_en,
  input  logic             urre_en,
  output logic             cpl_valid,
  output logic [STS_W-1:0] cpl_status,
  output logic             discard,
  output logic             serr_pulse
);

  logic             cpl_valid_d;
  logic [STS_W-1:0] cpl_status_d;
  logic             discard_d;
  logic             serr_d;
  cpl_sts_e         code;

  always_comb begin
    if (verdict.crs)     code = CPL_CRS;
    else if (verdict.ur) code = CPL_UR;
    else if (verdict.ca) code = CPL_CA;
    else                 code = CPL_SC;

    cpl_valid_d  = req_valid & verdict.np;
    cpl_status_d = cpl_valid_d ? code : CPL_SC;
    discard_d    = req_valid & (verdict.ur | verdict.ca);
    serr_d       = req_valid & ~verdict.np & (verdict.ur | verdict.ca)
                   & serr_en & urre_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid  <= 1'b0;
      cpl_status <= CPL_SC;
      discard    <= 1'b0;
      serr_pulse <= 1'b0;
    end else begin
      cpl_valid  <= cpl_valid_d;
      cpl_status <= cpl_status_d;
      discard    <= discard_d;
      serr_pulse <= serr_d;
    end
  end

  // R2
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid || discard || serr_pulse) |-> $past(req_valid));

  // R9
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> ($past(serr_en) && $past(urre_en) && !cpl_valid && discard));

  // R3
  posted_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |-> (cpl_status == CPL_SC));

  // R4
  crs_no_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_status == CPL_CRS) |-> (cpl_valid && !discard && !serr_pulse));

endmodule

// File: rtl/tgt_ur_sticky.sv
module tgt_ur_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ur,
  input  logic clr_w1c,
  output logic ur_detected
);

  logic ur_d;

  always_comb begin
    ur_d = ur_detected;
    if (clr_w1c) ur_d = 1'b0;
    if (set_ur)  ur_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ur_detected <= 1'b0;
    else        ur_detected <= ur_d;
  end

  // R11
  ur_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ur_detected) |-> $past(clr_w1c));

  // R10
  ur_set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ur_detected) |-> $past(set_ur));

endmodule

// File: rtl/tgt_cpl_classifier.sv
module tgt_cpl_classifier
  import tgt_cpl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_cfg,
  input  logic       req_posted,
  input  logic       req_supported,
  input  logic       req_model_err,
  input  logic       init_done,
  input  logic       pwr_d3,
  input  logic       serr_en,
  input  logic       urre_en,
  input  logic       ur_clear,
  output logic       cpl_valid,
  output logic [2:0] cpl_status,
  output logic       discard,
  output logic       serr_pulse,
  output logic       ur_detected
);

  verdict_t verdict;
  logic     ur_hit;

  tgt_req_decide u_decide (
    .req_cfg       (req_cfg),
    .req_posted    (req_posted),
    .req_supported (req_supported),
    .req_model_err (req_model_err),
    .init_done     (init_done),
    .pwr_d3        (pwr_d3),
    .verdict       (verdict)
  );

  tgt_resp_reg u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .verdict    (verdict),
    .serr_en    (serr_en),
    .urre_en    (urre_en),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .discard    (discard),
    .serr_pulse (serr_pulse)
  );

  assign ur_hit = req_valid & verdict.ur;

  tgt_ur_sticky u_sticky (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_ur      (ur_hit),
    .clr_w1c     (ur_clear),
    .ur_detected (ur_detected)
  );

  // R7
  ur_over_ca_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_supported && !(req_cfg && !init_done)) |=>
      (discard && ur_detected));

  // R6
  d3_mem_ur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pwr_d3 && !req_cfg) |=> (discard && ur_detected));

endmodule

// File: tb/tb_tgt_cpl_classifier.sv
module tb_tgt_cpl_classifier;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_cfg, req_posted, req_supported, req_model_err;
  logic       init_done, pwr_d3, serr_en, urre_en, ur_clear;
  logic       cpl_valid, discard, serr_pulse, ur_detected;
  logic [2:0] cpl_status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  tgt_cpl_classifier dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cfg(req_cfg),
    .req_posted(req_posted), .req_supported(req_supported),
    .req_model_err(req_model_err), .init_done(init_done), .pwr_d3(pwr_d3),
    .serr_en(serr_en), .urre_en(urre_en), .ur_clear(ur_clear),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .discard(discard),
    .serr_pulse(serr_pulse), .ur_detected(ur_detected)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_cfg = 0; req_posted = 0; req_supported = 1;
    req_model_err = 0; init_done = 1; pwr_d3 = 0; serr_en = 0; urre_en = 0;
    ur_clear = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({cpl_valid, cpl_status, discard, serr_pulse, ur_detected} == 0, "R1 reset",
        {cpl_valid, cpl_status, discard, serr_pulse, ur_detected}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({cpl_valid, cpl_status, discard, serr_pulse, ur_detected} == 0, "R1 after release",
        {cpl_valid, cpl_status, discard, serr_pulse, ur_detected}, 0);

    for (int v = 0; v < 256; v++) begin
      bit cfg, pst, sup, merr, ini, d3, se, ue;
      bit np, crs, ur, ca;
      int exp_sts;
      {cfg, pst, sup, merr, ini, d3, se, ue} = v[7:0];
      np  = cfg | ~pst;
      crs = cfg & ~ini;
      ur  = ~crs & (~sup | (d3 & ~cfg));
      ca  = ~crs & ~ur & merr;
      exp_sts = !np ? 0 : crs ? 2 : ur ? 1 : ca ? 4 : 0;

      // clear sticky flag alone (R11)
      ur_clear = 1;
      @(negedge clk);
      ur_clear = 0;
      chk(ur_detected == 0, "R11 clear", ur_detected, 0);

      req_valid = 1; req_cfg = cfg; req_posted = pst; req_supported = sup;
      req_model_err = merr; init_done = ini; pwr_d3 = d3; serr_en = se; urre_en = ue;
      @(negedge clk);
      idle_inputs();
      // R3 R4 R5 R6 R7 R8
      chk(cpl_valid == np, "R3 cpl_valid", cpl_valid, np);
      chk(cpl_status == exp_sts[2:0], "R4/R5/R6/R7/R8 status", cpl_status, exp_sts);
      chk(discard == (ur | ca), "R5 R7 discard", discard, ur | ca);
      // R9
      chk(serr_pulse == (~np & (ur | ca) & se & ue), "R9 serr", serr_pulse,
          ~np & (ur | ca) & se & ue);
      // R10
      chk(ur_detected == ur, "R10 sticky set", ur_detected, ur);

      @(negedge clk);
      // R2 idle cycle after request
      chk({cpl_valid, cpl_status, discard, serr_pulse} == 0, "R2 one cycle",
          {cpl_valid, cpl_status, discard, serr_pulse}, 0);
      chk(ur_detected == ur, "R10 sticky hold", ur_detected, ur);
    end

    // R11 clear and set in the same cycle: set wins
    ur_clear = 1;
    @(negedge clk);
    req_valid = 1; req_supported = 0; ur_clear = 1;
    @(negedge clk);
    idle_inputs();
    chk(ur_detected == 1, "R11 set wins", ur_detected, 1);
    @(negedge clk);
    chk(ur_detected == 1, "R10 sticky stays", ur_detected, 1);

    done = 1;
    finish_run();
  end

endmodule